// File: doc/BRIEF.md
# Converter Conversion-Start Sequencer

This block is the digital control side of a successive-approximation converter. It runs on the conversion clock. Every state change happens on the active edge of `clk`, which stands for the falling edge of that clock. An active-low convert request asks for a conversion. The sequencer enforces a minimum acquisition period after the previous conversion ends, then starts the conversion and frames the result with an end-of-conversion flag. The sixteen result bits come out one per cycle, most significant bit first. The top fourteen are data bits and the bottom two are sub-LSBs.

The analog comparator is replaced by a 16-bit input word, `sample_word`, which is captured on the start edge. Pulling `rst_n` low halts everything at once. When `rst_n` is released, a calibration period of `CAL_CYC` cycles follows. During that period `cal_busy` is high and conversions cannot start. The convert request is level-sensitive and is only looked at while the block is idle. A request that is low during calibration or during a conversion is not remembered.

The result stream has a valid flag (`bit_valid`) and no ready. The converter resolves one bit per cycle and cannot pause, so the consumer must take a bit on every cycle in which `bit_valid` is high. No back-pressure is possible.

Top module: `adc_start_seq`

## Requirements
- R1: While `rst_n` is low, `eoc`, `bit_valid` and `bit_out` are 0 and `cal_busy` is 1. This holds even if `rst_n` falls in the middle of a conversion, and it takes effect without waiting for an edge.
- R2: After `rst_n` rises, `cal_busy` stays 1 for exactly `CAL_CYC` edges. It reads 0 after the `CAL_CYC`-th edge, and no conversion starts while it is 1.
- R3: If `conv_n` is held low throughout calibration, the conversion starts on the first edge after `cal_busy` falls. `eoc` then rises one edge later, at edge `CAL_CYC`+2 counted from the release of `rst_n`.
- R4: If `conv_n` is first sampled low when at least 3 edges have passed since the previous conversion end, the conversion starts on that same edge.
- R5: If `conv_n` is low earlier than that, the conversion starts on the 4th edge after the previous conversion end.
- R6: `eoc` rises on the edge after the start edge and stays high for exactly 16 cycles. The edge on which it falls is the conversion end.
- R7: While `eoc` is high, `bit_valid` is 1 and `bit_out` carries bits 15 down to 0 of the captured word, one per cycle, bit 15 first. Bits 15..2 are data and bits 1..0 are the sub-LSBs. Outside that window `bit_valid` and `bit_out` are 0.
- R8: `sample_word` is captured on the start edge. Changes to it later in the conversion do not change the bits emitted.
- R9: `conv_n` is ignored while a conversion is in progress. A low pulse that ends before the conversion end produces no further conversion.
- R10: At least 4 cycles of acquisition always separate a conversion end from the next start. `eoc` is low for at least 5 consecutive sampled cycles before any rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; the active edge models the falling edge |
| rst_n | input | 1 | Active-low halt; release starts calibration |
| conv_n | input | 1 | Active-low convert request, level-sensitive while idle |
| sample_word | input | 16 | Stand-in for the resolved result, captured on the start edge |
| eoc | output | 1 | High for the 16 cycles that frame the result bits |
| bit_valid | output | 1 | Result stream valid, one bit per cycle, no ready |
| bit_out | output | 1 | Result bit, MSB first |
| cal_busy | output | 1 | Calibration in progress or halted |

## Verification
Four properties are checked on every cycle:
- the acquisition gap before each `eoc` rise (R10);
- the exact 16-cycle `eoc` width (R6);
- `eoc` staying low while calibration is pending;
- no start in the cycle right after calibration was busy.

Other behaviours need the bench's scenarios to show them:
- the exact start edge chosen by the three-cycle rule (R4, R5);
- bit order and word capture (R7, R8);
- requests dropped during a conversion (R9);
- calibration timing and a halt in mid-conversion (R1 to R3).

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARM   = 2'd1,
    SEQ_SHIFT = 2'd2
  } seq_state_t;
endpackage

// File: rtl/adc_seq_acq_timer.sv
// Saturating count of cycles since the last conversion end.
module adc_seq_acq_timer #(
  parameter int ACQ_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic acq_ready
);
  localparam int GAP_MAX = ACQ_CYC - 1;
  localparam int GW      = (GAP_MAX < 2) ? 1 : $clog2(GAP_MAX + 1);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    gap_q <= GW'(GAP_MAX);
    else if (clear)                gap_q <= '0;
    else if (gap_q != GW'(GAP_MAX)) gap_q <= gap_q + 1'b1;
  end

  assign acq_ready = (gap_q == GW'(GAP_MAX));
endmodule

// File: rtl/adc_seq_cal_timer.sv
// Fixed-length calibration busy period after reset release.
module adc_seq_cal_timer #(
  parameter int CAL_CYC = 24
) (
  input  logic clk,
  input  logic rst_n,
  output logic busy
);
  localparam int CW = (CAL_CYC < 2) ? 1 : $clog2(CAL_CYC);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == CW'(CAL_CYC - 1)) busy_q <= 1'b0;
      else                           cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/adc_seq_shifter.sv
// Captures the result word and presents it MSB first.
module adc_seq_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         msb
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (load)  sh_q <= din;
    else if (shift) sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign msb = sh_q[W-1];
endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W   = 16,
  parameter int ACQ_CYC = 4,
  parameter int CAL_CYC = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_n,
  input  logic [RES_W-1:0] sample_word,
  output logic             eoc,
  output logic             bit_valid,
  output logic             bit_out,
  output logic             cal_busy
);
  localparam int BW  = $clog2(RES_W);
  localparam int LRW = $clog2(ACQ_CYC + 2);
  localparam int HRW = $clog2(RES_W + 2);

  seq_state_t    state_q, state_d;
  logic [BW-1:0] bit_cnt_q;
  logic          acq_ready, start, last_bit, conv_end, do_shift, msb;

  adc_seq_cal_timer #(.CAL_CYC(CAL_CYC)) u_cal (
    .clk(clk), .rst_n(rst_n), .busy(cal_busy)
  );

  adc_seq_acq_timer #(.ACQ_CYC(ACQ_CYC)) u_acq (
    .clk(clk), .rst_n(rst_n), .clear(conv_end), .acq_ready(acq_ready)
  );

  adc_seq_shifter #(.W(RES_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .load(start), .shift(do_shift),
    .din(sample_word), .msb(msb)
  );

  // Requests are only looked at while idle; nothing is remembered.
  assign start    = (state_q == SEQ_IDLE) && !conv_n && acq_ready && !cal_busy;
  assign last_bit = (bit_cnt_q == BW'(RES_W - 1));
  assign conv_end = (state_q == SEQ_SHIFT) && last_bit;
  assign do_shift = (state_q == SEQ_SHIFT) && !last_bit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:  if (start) state_d = SEQ_ARM;
      SEQ_ARM:   state_d = SEQ_SHIFT;
      SEQ_SHIFT: if (last_bit) state_d = SEQ_IDLE;
      default:   state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_IDLE;
      bit_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q != SEQ_SHIFT) bit_cnt_q <= '0;
      else if (!last_bit)       bit_cnt_q <= bit_cnt_q + 1'b1;
    end
  end

  assign eoc       = (state_q == SEQ_SHIFT);
  assign bit_valid = eoc;
  assign bit_out   = eoc & msb;

  // Checker-side run-length counters on the eoc output.
  logic [LRW-1:0] low_run_q;
  logic [HRW-1:0] hi_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q <= LRW'(ACQ_CYC + 1);
      hi_run_q  <= '0;
    end else begin
      if (eoc) low_run_q <= '0;
      else if (low_run_q != LRW'(ACQ_CYC + 1)) low_run_q <= low_run_q + 1'b1;
      if (eoc) hi_run_q <= hi_run_q + 1'b1;
      else     hi_run_q <= '0;
    end
  end

  // R10: enough acquisition cycles before every eoc rise
  assert_acq_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> (low_run_q >= LRW'(ACQ_CYC + 1)));

  // R6: eoc frames exactly RES_W cycles
  assert_eoc_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc) |-> (hi_run_q == HRW'(RES_W)));

  // R2: no framing while calibration pending
  assert_cal_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> !eoc);

  // R3: a conversion never begins straight out of a busy cycle
  assert_no_start_in_cal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> !$past(cal_busy, 2));
endmodule

// File: tb/sim_adc_start_seq.sv
`timescale 1ns/1ps
module sim_adc_start_seq;
  localparam int W   = 16;
  localparam int CAL = 24;

  logic         clk = 1'b0;
  logic         rst_n, conv_n;
  logic [W-1:0] sample_word;
  logic         eoc, bit_valid, bit_out, cal_busy;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int t_end = -100;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_start_seq #(.RES_W(W), .ACQ_CYC(4), .CAL_CYC(CAL)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .sample_word(sample_word),
    .eoc(eoc), .bit_valid(bit_valid), .bit_out(bit_out), .cal_busy(cal_busy)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_start(input int req_edge, input int end_edge);
    return (req_edge > end_edge + 4) ? req_edge : end_edge + 4;
  endfunction

  // Collect 16 bits starting at the cycle where eoc was first seen high.
  task automatic collect(input logic [W-1:0] w, input bit busy_pulse);
    logic [W-1:0] got = '0;
    bit vbad = 0;
    sample_word = ~w;  // R8: late change must not matter
    for (int i = 0; i < W; i++) begin
      if (i > 0) tick();
      if (!bit_valid || !eoc) vbad = 1;
      got = {got[W-2:0], bit_out};
      if (busy_pulse && i == 3) conv_n = 1'b0;
      if (i == 9) conv_n = 1'b1;
    end
    check(!vbad, "R7", "bit_valid during frame", vbad, 0);
    check(got == w, "R8", "bits MSB first of captured word", got, w);
    tick();
    check(!eoc, "R6", "eoc low after 16 cycles", eoc, 0);
    check(!bit_valid && !bit_out, "R7", "stream quiet after frame",
          {bit_valid, bit_out}, 0);
    t_end = cyc;
    if (busy_pulse) begin
      bit seen = 0;
      for (int k = 0; k < 10; k++) begin tick(); if (eoc) seen = 1; end
      check(!seen, "R9", "no conversion from pulse during busy", seen, 0);
    end
  endtask

  task automatic run_conv(input logic [W-1:0] w, input int gap, input bit busy_pulse);
    int es, n;
    string req;
    sample_word = w;
    conv_n = 1'b1;
    repeat (gap) tick();
    conv_n = 1'b0;
    req = (cyc - t_end >= 3) ? "R4" : "R5";
    es = exp_start(cyc + 1, t_end);
    n = 0;
    while (!eoc && n < 60) begin tick(); n++; end
    check(cyc == es + 1, req, "eoc rise edge", cyc, es + 1);
    check(cyc - t_end >= 5, "R10", "acquisition gap", cyc - t_end, 5);
    conv_n = 1'b1;
    collect(w, busy_pulse);
  endtask

  initial begin
    int r, n;
    void'($urandom(32'd5150));
    rst_n = 1'b0; conv_n = 1'b0; sample_word = 16'h0;
    repeat (3) tick();
    check(!eoc && !bit_valid && !bit_out, "R1", "outputs quiet in reset",
          {eoc, bit_valid, bit_out}, 0);
    check(cal_busy, "R1", "busy in reset", cal_busy, 1);

    // Calibration with conv_n held low throughout
    sample_word = 16'hA5C3;
    rst_n = 1'b1;
    r = cyc;
    n = 0;
    while (cal_busy && n < 100) begin
      tick(); n++;
      if (eoc) check(0, "R3", "eoc during calibration", 1, 0);
    end
    check(cyc == r + CAL, "R2", "calibration length", cyc - r, CAL);
    n = 0;
    while (!eoc && n < 20) begin tick(); n++; end
    check(cyc == r + CAL + 2, "R3", "first eoc after calibration", cyc - r, CAL + 2);
    conv_n = 1'b1;
    collect(16'hA5C3, 0);

    // Directed gaps around the three-cycle threshold
    run_conv(16'hFFFF, 0, 0);
    run_conv(16'h0000, 1, 0);
    run_conv(16'h8001, 2, 0);
    run_conv(16'h1234, 3, 0);
    run_conv(16'h4002, 6, 0);
    run_conv(16'hBEEF, 0, 1);
    run_conv(16'h7FFE, 4, 0);

    // Random words and gaps
    for (int k = 0; k < 40; k++)
      run_conv(16'($urandom), int'($urandom % 7), ($urandom % 5) == 0);

    // Halt in mid-conversion
    sample_word = 16'hC0DE; conv_n = 1'b0;
    n = 0;
    while (!eoc && n < 20) begin tick(); n++; end
    conv_n = 1'b1;
    repeat (5) tick();
    rst_n = 1'b0;
    #0.5;
    check(!eoc && !bit_valid && !bit_out, "R1", "halt clears frame at once",
          {eoc, bit_valid, bit_out}, 0);
    check(cal_busy, "R1", "busy while halted", cal_busy, 1);
    repeat (2) tick();
    rst_n = 1'b1; r = cyc;
    n = 0;
    while (cal_busy && n < 100) begin tick(); n++; end
    check(cyc == r + CAL, "R2", "recalibration length", cyc - r, CAL);
    t_end = -100;
    run_conv(16'h0F0F, 2, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=%0d expected=done", cyc);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule